// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block moves 36-bit words between two independently clocked ports, A and B, through two separate first-in first-out buffers. The forward lane takes words written on port A and delivers them on port B. The return lane takes words written on port B and delivers them on port A. Each lane holds 64 words. The two clocks may be unrelated, or they may be the same clock.

A port writes into one lane and reads from the other. Its full and almost-full flags therefore describe the lane it writes into. Its empty and almost-empty flags describe the lane it reads from. All four flags of a port are produced in that port's own clock domain. Pointers cross between the domains in Gray code through a chain of synchronizer flops. Because of this delay, a flag can stay asserted for a few cycles after the far side has made room or supplied data. A flag never claims room or data that does not exist.

Each port has two threshold offsets. One sets where its almost-full flag asserts and the other sets where its almost-empty flag asserts. The offsets are captured while the port is in reset. Both ports are reset together before use.

Top module: `bidir_fifo_pair`

## Requirements
- R1: After both resets, `empty_*` and `aempty_*` are 1 and `full_*` and `afull_*` are 0 on both ports.
- R2: Words written on port A are read on port B in the same order with the same values, and likewise from B to A. Both lanes work concurrently without interfering.
- R3: Read data is registered. `rdata_*` keeps its old value until the rising edge at which `ren_*` is sampled high with the lane not empty, and shows the next word after that edge.
- R4: `full_*` goes high on the write edge that stores the 64th word. A write attempted while full stores nothing and does not move the write pointer. `full_*` rises only after a cycle in which `wen_*` was high.
- R5: A read attempted while empty leaves `rdata_*` unchanged and does not move the read pointer, so the next word written is the next word read.
- R6: `afull_*` is high exactly when the writer-side word count is at least 64 minus the port's almost-full offset. It is updated on the write edge.
- R7: `aempty_*` is high exactly when the reader-side word count is at most the port's almost-empty offset. It is updated on the read edge.
- R8: At every clock edge during reset, and at the first edge after reset is released, each offset register loads its 6-bit input if `thr_ld_*` is 1, or the value 8 otherwise. At all other edges, changes on `thr_ld_*` and the offset inputs have no effect.
- R9: Port A's `full_a`/`afull_a` describe the A-to-B lane and its `empty_a`/`aempty_a` describe the B-to-A lane. Port B is the mirror image.
- R10: Whenever a full flag is high, the matching almost-full flag is also high. Whenever an empty flag is high, the matching almost-empty flag is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| thr_ld_a | input | 1 | Use the port A offset inputs (rather than 8) during reset |
| af_ofs_a | input | 6 | Almost-full offset for the A-to-B lane |
| ae_ofs_a | input | 6 | Almost-empty offset for the B-to-A lane |
| wen_a | input | 1 | Write strobe into the A-to-B lane |
| wdata_a | input | 36 | Write data into the A-to-B lane |
| full_a | output | 1 | A-to-B lane full |
| afull_a | output | 1 | A-to-B lane almost full |
| ren_a | input | 1 | Read strobe from the B-to-A lane |
| rdata_a | output | 36 | Registered read data from the B-to-A lane |
| empty_a | output | 1 | B-to-A lane empty |
| aempty_a | output | 1 | B-to-A lane almost empty |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| thr_ld_b | input | 1 | Use the port B offset inputs (rather than 8) during reset |
| af_ofs_b | input | 6 | Almost-full offset for the B-to-A lane |
| ae_ofs_b | input | 6 | Almost-empty offset for the A-to-B lane |
| wen_b | input | 1 | Write strobe into the B-to-A lane |
| wdata_b | input | 36 | Write data into the B-to-A lane |
| full_b | output | 1 | B-to-A lane full |
| afull_b | output | 1 | B-to-A lane almost full |
| ren_b | input | 1 | Read strobe from the A-to-B lane |
| rdata_b | output | 36 | Registered read data from the A-to-B lane |
| empty_b | output | 1 | A-to-B lane empty |
| aempty_b | output | 1 | A-to-B lane almost empty |

## Verification
A write or read pointer that slips by one shows up at the read port on the very next word read: that word is either duplicated or skipped. The scoreboard compares every word, so the error is caught there. A wrong offset register, or a wrong level computation, moves the almost flags by one position. The bench probes these flags at the exact word counts on either side of each threshold, right after the write or read edge that crosses it. A broken Gray conversion or synchronizer chain leaves a remote flag stuck, or lets it pass bad data. This appears either as an empty lane that never releases, which the watchdog ends, or as corrupted words in the scoreboard within a few reader cycles.

// File: rtl/fifo_pair_pkg.sv
`timescale 1ns/1ps
package fifo_pair_pkg;

   localparam int unsigned PAIR_DATA_W      = 36;
   localparam int unsigned PAIR_ADDR_W      = 6;
   localparam int unsigned PAIR_OFS_W       = 6;
   localparam int unsigned PAIR_THR_DEF     = 8;
   localparam int unsigned PAIR_SYNC_STAGES = 2;

   typedef struct packed {
      logic full;
      logic afull;
   } wr_flags_t;

   typedef struct packed {
      logic empty;
      logic aempty;
   } rd_flags_t;

endpackage

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
   parameter int unsigned W      = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] gray_out
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= gray_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign gray_out = chain[STAGES-1];

endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
   import fifo_pair_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned OFS_W   = 6,
   parameter int unsigned THR_DEF = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_ld,
   input  logic [OFS_W-1:0]  ofs_in,
   input  logic              wen,
   input  logic [ADDR_W:0]   rgray_s,
   output logic [ADDR_W-1:0] waddr,
   output logic              we,
   output logic [ADDR_W:0]   wgray,
   output wr_flags_t         flags
);

   localparam int unsigned   PW       = ADDR_W + 1;
   localparam logic [PW-1:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};

   logic [PW-1:0]    wbin;
   logic [PW-1:0]    wbin_nx;
   logic [PW-1:0]    rbin_s;
   logic [PW-1:0]    level;
   logic [PW-1:0]    thr_ext;
   logic [OFS_W-1:0] thr;
   logic             rst_q;

   // gray to binary on the synchronized read pointer
   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign level       = wbin - rbin_s;
   assign thr_ext     = PW'(thr);
   assign flags.full  = (level == FULL_LVL);
   assign flags.afull = (level >= (FULL_LVL - thr_ext));
   assign we          = wen & ~flags.full;
   assign wbin_nx     = wbin + PW'(1);
   assign waddr       = wbin[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   // registered reset indicator gates the offset capture window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b1;
      else        rst_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst_q) thr <= thr_ld ? ofs_in : OFS_W'(THR_DEF);
   end

endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
   import fifo_pair_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned OFS_W   = 6,
   parameter int unsigned THR_DEF = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_ld,
   input  logic [OFS_W-1:0]  ofs_in,
   input  logic              ren,
   input  logic [ADDR_W:0]   wgray_s,
   output logic [ADDR_W-1:0] raddr,
   output logic              re,
   output logic [ADDR_W:0]   rgray,
   output rd_flags_t         flags
);

   localparam int unsigned PW = ADDR_W + 1;

   logic [PW-1:0]    rbin;
   logic [PW-1:0]    rbin_nx;
   logic [PW-1:0]    wbin_s;
   logic [PW-1:0]    level;
   logic [PW-1:0]    thr_ext;
   logic [OFS_W-1:0] thr;
   logic             rst_q;

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end

   assign level        = wbin_s - rbin;
   assign thr_ext      = PW'(thr);
   assign flags.empty  = (level == '0);
   assign flags.aempty = (level <= thr_ext);
   assign re           = ren & ~flags.empty;
   assign rbin_nx      = rbin + PW'(1);
   assign raddr        = rbin[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (re) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b1;
      else        rst_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst_q) thr <= thr_ld ? ofs_in : OFS_W'(THR_DEF);
   end

endmodule

// File: rtl/fifo_lane.sv
`timescale 1ns/1ps
module fifo_lane
   import fifo_pair_pkg::*;
#(
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned OFS_W       = 6,
   parameter int unsigned THR_DEF     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RD_RESET    = 1'b1
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wthr_ld,
   input  logic [OFS_W-1:0]  waf_ofs,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   output wr_flags_t         wflags,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rthr_ld,
   input  logic [OFS_W-1:0]  rae_ofs,
   input  logic              ren,
   output logic [DATA_W-1:0] rdata,
   output rd_flags_t         rflags
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic              we;
   logic              re;
   logic [ADDR_W:0]   wgray;
   logic [ADDR_W:0]   rgray;
   logic [ADDR_W:0]   wgray_s;
   logic [ADDR_W:0]   rgray_s;

   fifo_wr_ctl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .THR_DEF(THR_DEF)) u_wr (
      .clk(wclk), .rst_n(wrst_n), .thr_ld(wthr_ld), .ofs_in(waf_ofs),
      .wen(wen), .rgray_s(rgray_s), .waddr(waddr), .we(we),
      .wgray(wgray), .flags(wflags)
   );

   fifo_rd_ctl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .THR_DEF(THR_DEF)) u_rd (
      .clk(rclk), .rst_n(rrst_n), .thr_ld(rthr_ld), .ofs_in(rae_ofs),
      .ren(ren), .wgray_s(wgray_s), .raddr(raddr), .re(re),
      .rgray(rgray), .flags(rflags)
   );

   fifo_ptr_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .gray_out(wgray_s)
   );

   fifo_ptr_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .gray_out(rgray_s)
   );

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (RD_RESET) begin : g_rd_rst
         always_ff @(posedge rclk or negedge rrst_n) begin
            if (!rrst_n)  rdata <= '0;
            else if (re)  rdata <= mem[raddr];
         end
      end else begin : g_rd_plain
         always_ff @(posedge rclk) begin
            if (re) rdata <= mem[raddr];
         end
      end
   endgenerate

endmodule

// File: rtl/bidir_fifo_pair.sv
`timescale 1ns/1ps
module bidir_fifo_pair
   import fifo_pair_pkg::*;
#(
   parameter int unsigned DATA_W      = PAIR_DATA_W,
   parameter int unsigned ADDR_W      = PAIR_ADDR_W,
   parameter int unsigned OFS_W       = PAIR_OFS_W,
   parameter int unsigned THR_DEF     = PAIR_THR_DEF,
   parameter int unsigned SYNC_STAGES = PAIR_SYNC_STAGES,
   parameter bit          RD_RESET    = 1'b1
) (
   input  logic              clk_a,
   input  logic              rst_a_n,
   input  logic              thr_ld_a,
   input  logic [OFS_W-1:0]  af_ofs_a,
   input  logic [OFS_W-1:0]  ae_ofs_a,
   input  logic              wen_a,
   input  logic [DATA_W-1:0] wdata_a,
   output logic              full_a,
   output logic              afull_a,
   input  logic              ren_a,
   output logic [DATA_W-1:0] rdata_a,
   output logic              empty_a,
   output logic              aempty_a,
   input  logic              clk_b,
   input  logic              rst_b_n,
   input  logic              thr_ld_b,
   input  logic [OFS_W-1:0]  af_ofs_b,
   input  logic [OFS_W-1:0]  ae_ofs_b,
   input  logic              wen_b,
   input  logic [DATA_W-1:0] wdata_b,
   output logic              full_b,
   output logic              afull_b,
   input  logic              ren_b,
   output logic [DATA_W-1:0] rdata_b,
   output logic              empty_b,
   output logic              aempty_b
);

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("bidir_fifo_pair: ADDR_W must lie in 2..12");
      end
      if (OFS_W > ADDR_W) begin : g_bad_ofs
         $error("bidir_fifo_pair: OFS_W may not exceed ADDR_W");
      end
      if (THR_DEF >= (1 << OFS_W)) begin : g_bad_def
         $error("bidir_fifo_pair: THR_DEF does not fit in OFS_W bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bidir_fifo_pair: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("bidir_fifo_pair: DATA_W must be positive");
      end
   endgenerate

   wr_flags_t ab_wf;
   rd_flags_t ab_rf;
   wr_flags_t ba_wf;
   rd_flags_t ba_rf;

   // forward lane: written on A, read on B
   fifo_lane #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .THR_DEF(THR_DEF),
      .SYNC_STAGES(SYNC_STAGES), .RD_RESET(RD_RESET)
   ) u_lane_ab (
      .wclk(clk_a), .wrst_n(rst_a_n), .wthr_ld(thr_ld_a), .waf_ofs(af_ofs_a),
      .wen(wen_a), .wdata(wdata_a), .wflags(ab_wf),
      .rclk(clk_b), .rrst_n(rst_b_n), .rthr_ld(thr_ld_b), .rae_ofs(ae_ofs_b),
      .ren(ren_b), .rdata(rdata_b), .rflags(ab_rf)
   );

   // return lane: written on B, read on A
   fifo_lane #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .THR_DEF(THR_DEF),
      .SYNC_STAGES(SYNC_STAGES), .RD_RESET(RD_RESET)
   ) u_lane_ba (
      .wclk(clk_b), .wrst_n(rst_b_n), .wthr_ld(thr_ld_b), .waf_ofs(af_ofs_b),
      .wen(wen_b), .wdata(wdata_b), .wflags(ba_wf),
      .rclk(clk_a), .rrst_n(rst_a_n), .rthr_ld(thr_ld_a), .rae_ofs(ae_ofs_a),
      .ren(ren_a), .rdata(rdata_a), .rflags(ba_rf)
   );

   assign full_a   = ab_wf.full;
   assign afull_a  = ab_wf.afull;
   assign empty_a  = ba_rf.empty;
   assign aempty_a = ba_rf.aempty;
   assign full_b   = ba_wf.full;
   assign afull_b  = ba_wf.afull;
   assign empty_b  = ab_rf.empty;
   assign aempty_b = ab_rf.aempty;

endmodule

// File: rtl/bidir_fifo_pair_chk.sv
`timescale 1ns/1ps
module bidir_fifo_pair_chk #(
   parameter int unsigned DATA_W = 36
) (
   input logic              clk_a,
   input logic              rst_a_n,
   input logic              wen_a,
   input logic              ren_a,
   input logic              full_a,
   input logic              afull_a,
   input logic              empty_a,
   input logic              aempty_a,
   input logic [DATA_W-1:0] rdata_a,
   input logic              clk_b,
   input logic              rst_b_n,
   input logic              wen_b,
   input logic              ren_b,
   input logic              full_b,
   input logic              afull_b,
   input logic              empty_b,
   input logic              aempty_b,
   input logic [DATA_W-1:0] rdata_b
);

   // R10
   full_af_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      full_a |-> afull_a);
   // R10
   full_af_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      full_b |-> afull_b);
   // R10
   empty_ae_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      empty_a |-> aempty_a);
   // R10
   empty_ae_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      empty_b |-> aempty_b);
   // R5
   rd_empty_hold_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (ren_a && empty_a) |=> $stable(rdata_a));
   // R5
   rd_empty_hold_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (ren_b && empty_b) |=> $stable(rdata_b));
   // R4
   full_rise_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      $rose(full_a) |-> $past(wen_a));
   // R4
   full_rise_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      $rose(full_b) |-> $past(wen_b));

endmodule

bind bidir_fifo_pair bidir_fifo_pair_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_a(clk_a), .rst_a_n(rst_a_n), .wen_a(wen_a), .ren_a(ren_a),
   .full_a(full_a), .afull_a(afull_a), .empty_a(empty_a), .aempty_a(aempty_a),
   .rdata_a(rdata_a),
   .clk_b(clk_b), .rst_b_n(rst_b_n), .wen_b(wen_b), .ren_b(ren_b),
   .full_b(full_b), .afull_b(afull_b), .empty_b(empty_b), .aempty_b(aempty_b),
   .rdata_b(rdata_b)
);

// File: tb/bidir_fifo_pair_test.sv
`timescale 1ns/1ps
module bidir_fifo_pair_test;

   logic        clk_a = 1'b0;
   logic        clk_b = 1'b0;
   logic        rst_a_n = 1'b0;
   logic        rst_b_n = 1'b0;
   logic        thr_ld_a = 1'b0;
   logic        thr_ld_b = 1'b0;
   logic [5:0]  af_ofs_a = '0;
   logic [5:0]  ae_ofs_a = '0;
   logic [5:0]  af_ofs_b = '0;
   logic [5:0]  ae_ofs_b = '0;
   logic        wen_a = 1'b0;
   logic        wen_b = 1'b0;
   logic        ren_a = 1'b0;
   logic        ren_b = 1'b0;
   logic [35:0] wdata_a = '0;
   logic [35:0] wdata_b = '0;
   logic [35:0] rdata_a;
   logic [35:0] rdata_b;
   logic        full_a, afull_a, empty_a, aempty_a;
   logic        full_b, afull_b, empty_b, aempty_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int seq_ab = 0;
   int seq_ba = 0;
   logic [35:0] q_ab [$];
   logic [35:0] q_ba [$];

   always #5 clk_a = ~clk_a;
   always #7 clk_b = ~clk_b;

   bidir_fifo_pair uut (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .thr_ld_a(thr_ld_a),
      .af_ofs_a(af_ofs_a), .ae_ofs_a(ae_ofs_a),
      .wen_a(wen_a), .wdata_a(wdata_a), .full_a(full_a), .afull_a(afull_a),
      .ren_a(ren_a), .rdata_a(rdata_a), .empty_a(empty_a), .aempty_a(aempty_a),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .thr_ld_b(thr_ld_b),
      .af_ofs_b(af_ofs_b), .ae_ofs_b(ae_ofs_b),
      .wen_b(wen_b), .wdata_b(wdata_b), .full_b(full_b), .afull_b(afull_b),
      .ren_b(ren_b), .rdata_b(rdata_b), .empty_b(empty_b), .aempty_b(aempty_b)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic logic [35:0] mk(input bit dir_ba, input int seq);
      return {dir_ba ? 4'hB : 4'hA, 32'(seq)};
   endfunction

   task automatic do_reset(input bit lda, input logic [5:0] afa, input logic [5:0] aea,
                           input bit ldb, input logic [5:0] afb, input logic [5:0] aeb);
      rst_a_n = 1'b0; rst_b_n = 1'b0;
      wen_a = 0; wen_b = 0; ren_a = 0; ren_b = 0;
      thr_ld_a = lda; af_ofs_a = afa; ae_ofs_a = aea;
      thr_ld_b = ldb; af_ofs_b = afb; ae_ofs_b = aeb;
      q_ab.delete(); q_ba.delete();
      repeat (4) @(posedge clk_b);
      @(negedge clk_a) rst_a_n = 1'b1;
      @(negedge clk_b) rst_b_n = 1'b1;
      repeat (3) @(negedge clk_b);
      // R8: offsets changed after reset must not take effect
      thr_ld_a = 1'b1; af_ofs_a = 6'd20; ae_ofs_a = 6'd30;
      thr_ld_b = 1'b1; af_ofs_b = 6'd21; ae_ofs_b = 6'd31;
      repeat (2) @(negedge clk_a);
   endtask

   // driver: pushes every accepted word to the scoreboard queue
   task automatic write_a(input int n);
      int cnt = 0;
      while (cnt < n) begin
         @(negedge clk_a);
         if (!full_a) begin
            wen_a = 1'b1; wdata_a = mk(1'b0, seq_ab);
            q_ab.push_back(wdata_a); seq_ab++; cnt++;
         end else wen_a = 1'b0;
      end
      @(negedge clk_a) wen_a = 1'b0;
   endtask

   task automatic write_b(input int n);
      int cnt = 0;
      while (cnt < n) begin
         @(negedge clk_b);
         if (!full_b) begin
            wen_b = 1'b1; wdata_b = mk(1'b1, seq_ba);
            q_ba.push_back(wdata_b); seq_ba++; cnt++;
         end else wen_b = 1'b0;
      end
      @(negedge clk_b) wen_b = 1'b0;
   endtask

   // monitor: pops the expected word when the registered data arrives
   task automatic read_b(input int n);
      int got = 0;
      bit pend = 1'b0;
      logic [35:0] exp;
      while (got < n || pend) begin
         @(negedge clk_b);
         if (pend) begin
            exp = (q_ab.size() > 0) ? q_ab.pop_front() : 'x;
            chk("R2 A-to-B data", 64'(rdata_b), 64'(exp));
            pend = 1'b0;
         end
         if (got < n && !empty_b) begin
            ren_b = 1'b1; pend = 1'b1; got++;
         end else ren_b = 1'b0;
      end
      ren_b = 1'b0;
   endtask

   task automatic read_a(input int n);
      int got = 0;
      bit pend = 1'b0;
      logic [35:0] exp;
      while (got < n || pend) begin
         @(negedge clk_a);
         if (pend) begin
            exp = (q_ba.size() > 0) ? q_ba.pop_front() : 'x;
            chk("R2 B-to-A data", 64'(rdata_a), 64'(exp));
            pend = 1'b0;
         end
         if (got < n && !empty_a) begin
            ren_a = 1'b1; pend = 1'b1; got++;
         end else ren_a = 1'b0;
      end
      ren_a = 1'b0;
   endtask

   initial begin
      #500us;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [35:0] hold;
      logic [35:0] exp;

      // ---- test 1: default offsets, reset state
      do_reset(1'b0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0);
      chk("R1 empty_a",  64'(empty_a),  64'd1);
      chk("R1 aempty_a", 64'(aempty_a), 64'd1);
      chk("R1 full_a",   64'(full_a),   64'd0);
      chk("R1 afull_a",  64'(afull_a),  64'd0);
      chk("R1 empty_b",  64'(empty_b),  64'd1);
      chk("R1 aempty_b", 64'(aempty_b), 64'd1);
      chk("R1 full_b",   64'(full_b),   64'd0);
      chk("R1 afull_b",  64'(afull_b),  64'd0);

      // ---- test 2: fill the A-to-B lane
      write_a(55);
      chk("R6 afull_a at 55 words", 64'(afull_a), 64'd0);
      write_a(1);
      chk("R6 R8 afull_a at 56 words (default 8)", 64'(afull_a), 64'd1);
      write_a(7);
      chk("R4 full_a at 63 words", 64'(full_a), 64'd0);
      write_a(1);
      chk("R4 full_a at 64 words", 64'(full_a), 64'd1);
      chk("R10 afull_a while full", 64'(afull_a), 64'd1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_a); wen_a = 1'b1; wdata_a = 36'hDEAD0BEEF;
         @(negedge clk_a); wen_a = 1'b0;
      end
      chk("R4 full_a after rejected writes", 64'(full_a), 64'd1);
      repeat (5) @(negedge clk_b);
      chk("R9 empty_b sees A-to-B words", 64'(empty_b), 64'd0);
      chk("R9 full_b untouched", 64'(full_b), 64'd0);
      chk("R9 empty_a untouched", 64'(empty_a), 64'd1);
      chk("R7 aempty_b at 64 words", 64'(aempty_b), 64'd0);
      read_b(55);
      chk("R7 aempty_b at 9 words", 64'(aempty_b), 64'd0);
      read_b(1);
      chk("R7 aempty_b at 8 words", 64'(aempty_b), 64'd1);
      read_b(8);
      chk("R4 R2 empty_b after 64 reads", 64'(empty_b), 64'd1);
      chk("R2 scoreboard A-to-B drained", 64'(q_ab.size()), 64'd0);

      // read while empty
      hold = rdata_b;
      @(negedge clk_b) ren_b = 1'b1;
      @(negedge clk_b) ren_b = 1'b0;
      chk("R5 rdata_b held on empty read", 64'(rdata_b), 64'(hold));
      chk("R5 empty_b still set", 64'(empty_b), 64'd1);

      // registered read timing and pointer integrity
      write_a(1);
      repeat (5) @(negedge clk_b);
      hold = rdata_b;
      exp  = q_ab.pop_front();
      @(negedge clk_b) ren_b = 1'b1;
      #1;
      chk("R3 rdata_b before edge", 64'(rdata_b), 64'(hold));
      @(negedge clk_b) ren_b = 1'b0;
      chk("R3 R5 rdata_b after edge", 64'(rdata_b), 64'(exp));
      repeat (5) @(negedge clk_a);
      chk("R4 full_a clears after drain", 64'(full_a), 64'd0);
      chk("R6 afull_a clears after drain", 64'(afull_a), 64'd0);

      // ---- test 3: loaded offsets on the B-to-A lane
      do_reset(1'b1, 6'd8, 6'd2, 1'b1, 6'd3, 6'd8);
      write_b(60);
      chk("R8 R6 afull_b at 60 words (offset 3)", 64'(afull_b), 64'd0);
      write_b(1);
      chk("R8 R6 afull_b at 61 words (offset 3)", 64'(afull_b), 64'd1);
      repeat (5) @(negedge clk_a);
      read_a(58);
      chk("R8 R7 aempty_a at 3 words (offset 2)", 64'(aempty_a), 64'd0);
      read_a(1);
      chk("R8 R7 aempty_a at 2 words (offset 2)", 64'(aempty_a), 64'd1);
      read_a(2);
      chk("R2 empty_a after drain", 64'(empty_a), 64'd1);

      // ---- test 4: both lanes streaming at once
      fork
         write_a(200);
         read_b(200);
         write_b(200);
         read_a(200);
      join
      chk("R2 scoreboard A-to-B empty", 64'(q_ab.size()), 64'd0);
      chk("R2 scoreboard B-to-A empty", 64'(q_ba.size()), 64'd0);
      chk("R2 empty_a at end", 64'(empty_a), 64'd1);
      chk("R2 empty_b at end", 64'(empty_b), 64'd1);

      finish_run();
   end

endmodule